// File: doc/BRIEF.md
# Disk Interface Control and Drive-Address Registers

This block holds the host-facing device-control register of a parallel disk task-file interface and builds the matching read-only drive-address value. A host write decoded as a device-control access latches three live fields: a high-order-byte flag, a soft-reset request and an inverted interrupt enable. A write decoded as any command-block access clears the high-order-byte flag. The soft-reset request only takes effect after it has been held for a minimum time. That time is derived from the block clock frequency and the required hold time, both given as parameters.

The device interrupt request reaches the host only when the inverted enable is low and this device is the one the device/head register currently selects. A strap input tells the block whether it sits at device position 0 or 1. The drive-address value is formed each cycle from the current head number, the write-in-progress indication and the selection state, all in active-low form. Its top bit is never driven, so the bus sees whatever pull level the board provides.

Top module: `disk_ctl_regs`

## Requirements
- R1: While reset is asserted, and after it is released with no writes, the control readback is 0x08, `soft_rst` is 0 and `irq_out` is 0.
- R2: A device-control write (`host_wr` and `ctl_sel` high) latches data bit 7 as the high-order-byte flag, bit 2 as the soft-reset request and bit 1 as the inverted interrupt enable. The control readback after that edge is {flag, 000, 1, request, inverted-enable, 0}.
- R3: A command-block write (`host_wr` and `cmd_sel` high) with no device-control write in the same cycle clears the high-order-byte flag at that edge. When both selects are high, the device-control data is taken.
- R4: `soft_rst` rises exactly MIN_CYC clock edges after the edge that set the soft-reset request. It stays high while the request stays set and falls at the edge that clears the request. MIN_CYC is CLK_KHZ*RESET_MIN_US/1000.
- R5: A soft-reset request held for fewer than MIN_CYC edges never raises `soft_rst`.
- R6: After each edge, `irq_out` equals `dev_irq` AND NOT inverted-enable AND (`dev_bit` == `dev_strap`), taken from the values just before that edge.
- R7: Drive-address bits 5..2 are the one's complement of `head_num`, with head bit 0 at address bit 2. This holds in the same cycle.
- R8: Drive-address bit 6 is the inverse of `media_wr`: it is 0 while a media write is in progress.
- R9: Drive-address bit 0 is 0 exactly when `dev_bit` is 0 and `dev_active` is 1. Bit 1 is 0 exactly when `dev_bit` is 1 and `dev_active` is 1.
- R10: `dar_oe` is 0x7F: bits 6..0 are driven and bit 7 is never enabled, so bit 7 on the bus is the pulled-high level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Host write strobe, one cycle per write |
| ctl_sel | input | 1 | Decode: write targets the device-control register |
| cmd_sel | input | 1 | Decode: write targets a command-block register |
| host_wdata | input | 8 | Host write data |
| dev_bit | input | 1 | Device-select bit from the device/head register |
| dev_strap | input | 1 | This device's position (0 or 1) |
| dev_active | input | 1 | Selected device is active |
| head_num | input | 4 | Binary number of the selected head |
| media_wr | input | 1 | Media write in progress |
| dev_irq | input | 1 | Raw device interrupt request |
| ctl_rd | output | 8 | Device-control register contents |
| soft_rst | output | 1 | Qualified soft reset to the device |
| irq_out | output | 1 | Gated interrupt request to the host |
| dar_rd | output | 8 | Drive-address value |
| dar_oe | output | 8 | Per-bit output enable for the drive-address value |

## Verification
The drive-address value and its enables are combinational, so the bench checks them one nanosecond after it changes the inputs, before the next edge. The control readback and `irq_out` are due one edge after the write or input that causes them. `soft_rst` is due MIN_CYC edges after the request is set and falls on the clearing edge. The bench updates its model at each rising edge from the inputs it held during the prior half cycle, and compares the registered outputs one nanosecond after that edge. Directed holds of MIN_CYC-1 and MIN_CYC edges bracket the reset threshold.

// File: rtl/disk_ctl_regs.sv
module disk_ctl_regs #(
  parameter int CLK_KHZ      = 50000,
  parameter int RESET_MIN_US = 5000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_wr,
  input  logic       ctl_sel,
  input  logic       cmd_sel,
  input  logic [7:0] host_wdata,
  input  logic       dev_bit,
  input  logic       dev_strap,
  input  logic       dev_active,
  input  logic [3:0] head_num,
  input  logic       media_wr,
  input  logic       dev_irq,
  output logic [7:0] ctl_rd,
  output logic       soft_rst,
  output logic       irq_out,
  output logic [7:0] dar_rd,
  output logic [7:0] dar_oe
);

  localparam int MIN_CYC = ((CLK_KHZ * RESET_MIN_US) / 1000 < 1) ? 1 : (CLK_KHZ * RESET_MIN_US) / 1000;
  localparam int CW      = $clog2(MIN_CYC + 1);

  logic          hob, srst, nien;
  logic [CW-1:0] hold_cnt;
  logic          ctl_wr, cmd_wr, selected;
  logic          unused_wdata;

  assign ctl_wr       = host_wr & ctl_sel;
  assign cmd_wr       = host_wr & cmd_sel & ~ctl_sel;
  assign selected     = (dev_bit == dev_strap);
  assign unused_wdata = ^{host_wdata[6:3], host_wdata[0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hob  <= 1'b0;
      srst <= 1'b0;
      nien <= 1'b0;
    end else if (ctl_wr) begin
      hob  <= host_wdata[7];
      srst <= host_wdata[2];
      nien <= host_wdata[1];
    end else if (cmd_wr) begin
      hob  <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      hold_cnt <= '0;
    else if (!srst)
      hold_cnt <= '0;
    else if (hold_cnt != CW'(MIN_CYC))
      hold_cnt <= hold_cnt + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_out <= 1'b0;
    else        irq_out <= dev_irq & ~nien & selected;
  end

  assign soft_rst = srst & (hold_cnt == CW'(MIN_CYC));
  assign ctl_rd   = {hob, 3'b000, 1'b1, srst, nien, 1'b0};

  assign dar_rd = {1'b0, ~media_wr, ~head_num, ~(dev_bit & dev_active), ~(~dev_bit & dev_active)};
  assign dar_oe = 8'h7F;

  AST_CTL_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> (ctl_rd[7] == $past(host_wdata[7]) && ctl_rd[2] == $past(host_wdata[2]) && ctl_rd[1] == $past(host_wdata[1]))); // R2
  AST_HOB_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && cmd_sel && !ctl_sel) |=> !ctl_rd[7]); // R3
  AST_SRST_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(soft_rst) |-> $past(srst)); // R4
  AST_SRST_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !srst |-> !soft_rst); // R5
  AST_IRQ_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (nien || !selected) |=> !irq_out); // R6

endmodule

// File: tb/sim_disk_ctl_regs.sv
module sim_disk_ctl_regs;
  localparam int KHZ  = 10;
  localparam int US   = 5000;
  localparam int MINC = 50;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n, host_wr, ctl_sel, cmd_sel, dev_bit, dev_strap, dev_active, media_wr, dev_irq;
  logic [7:0] host_wdata;
  logic [3:0] head_num;
  logic [7:0] ctl_rd, dar_rd, dar_oe;
  logic       soft_rst, irq_out;

  disk_ctl_regs #(.CLK_KHZ(KHZ), .RESET_MIN_US(US)) u0 (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .ctl_sel(ctl_sel), .cmd_sel(cmd_sel),
    .host_wdata(host_wdata), .dev_bit(dev_bit), .dev_strap(dev_strap), .dev_active(dev_active),
    .head_num(head_num), .media_wr(media_wr), .dev_irq(dev_irq), .ctl_rd(ctl_rd),
    .soft_rst(soft_rst), .irq_out(irq_out), .dar_rd(dar_rd), .dar_oe(dar_oe));

  int n_chk = 0;
  int n_fail = 0;
  logic m_hob = 0, m_srst = 0, m_nien = 0, m_irq = 0;
  int   m_cnt = 0;
  int   soft_seen = 0;

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] exp_dar(logic mw, logic [3:0] hd, logic db, logic act);
    return {1'b1, ~mw, ~hd, ~(db & act), ~(~db & act)};
  endfunction

  function automatic logic [7:0] exp_ctl(logic h, logic s, logic n);
    return {h, 3'b000, 1'b1, s, n, 1'b0};
  endfunction

  task automatic tick();
    logic [7:0] bus;
    #1;
    bus = (dar_rd & dar_oe) | ~dar_oe;
    chk("R7 R8 R9 R10 drive-address", bus, exp_dar(media_wr, head_num, dev_bit, dev_active));
    chk("R10 output enable", dar_oe, 8'h7F);
    @(posedge clk);
    m_irq = dev_irq & ~m_nien & (dev_bit == dev_strap);
    if (m_srst) begin
      if (m_cnt < MINC) m_cnt++;
    end else m_cnt = 0;
    if (host_wr && ctl_sel) begin
      m_hob = host_wdata[7]; m_srst = host_wdata[2]; m_nien = host_wdata[1];
    end else if (host_wr && cmd_sel) m_hob = 1'b0;
    #1;
    chk("R2 R3 control readback", ctl_rd, exp_ctl(m_hob, m_srst, m_nien));
    chk("R4 R5 soft reset", {7'd0, soft_rst}, {7'd0, m_srst && m_cnt == MINC});
    chk("R6 interrupt", {7'd0, irq_out}, {7'd0, m_irq});
    if (soft_rst) soft_seen++;
    @(negedge clk);
  endtask

  task automatic idle();
    host_wr = 0; ctl_sel = 0; cmd_sel = 0; host_wdata = 8'h00;
  endtask

  task automatic wr(logic c, logic k, logic [7:0] d);
    host_wr = 1; ctl_sel = c; cmd_sel = k; host_wdata = d;
    tick();
    idle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 0; idle();
    dev_bit = 0; dev_strap = 0; dev_active = 0; media_wr = 0; dev_irq = 0; head_num = 4'h0;
    repeat (3) @(negedge clk);
    chk("R1 reset control", ctl_rd, 8'h08);
    chk("R1 reset soft", {7'd0, soft_rst}, 8'h00);
    chk("R1 reset irq", {7'd0, irq_out}, 8'h00);
    rst_n = 1;
    tick();
    chk("R1 idle control", ctl_rd, 8'h08);

    wr(1, 0, 8'h82);
    chk("R2 flag and enable", ctl_rd, 8'h8A);
    wr(0, 1, 8'h55);
    chk("R3 cmd write clears flag", ctl_rd, 8'h0A);
    wr(1, 0, 8'hF9);
    chk("R2 reserved bits ignored", ctl_rd, 8'h88);
    wr(1, 1, 8'h80);
    chk("R3 ctl wins on dual select", ctl_rd, 8'h88);
    wr(1, 0, 8'h00);

    soft_seen = 0;
    wr(1, 0, 8'h04);
    repeat (MINC - 1) tick();
    wr(1, 0, 8'h00);
    chk("R5 short hold ignored", soft_seen[7:0], 8'd0);

    soft_seen = 0;
    wr(1, 0, 8'h04);
    repeat (MINC - 1) tick();
    chk("R4 not yet at MIN-1", {7'd0, soft_rst}, 8'h00);
    tick();
    chk("R4 asserted at MIN", {7'd0, soft_rst}, 8'h01);
    repeat (5) tick();
    chk("R4 held", {7'd0, soft_rst}, 8'h01);
    wr(1, 0, 8'h00);
    chk("R4 drops on clear", {7'd0, soft_rst}, 8'h00);

    for (int h = 0; h < 16; h++) begin
      head_num = 4'(h); media_wr = h[0]; dev_bit = h[1]; dev_active = h[2];
      dev_strap = h[3]; dev_irq = 1;
      tick();
    end

    for (int i = 0; i < 4000; i++) begin
      dev_bit = 1'($urandom); dev_strap = 1'($urandom); dev_active = 1'($urandom);
      media_wr = 1'($urandom); dev_irq = 1'($urandom); head_num = 4'($urandom);
      if ($urandom % 6 == 0) begin
        host_wr = 1;
        ctl_sel = ($urandom % 3 == 0);
        cmd_sel = 1'($urandom);
        host_wdata = 8'($urandom);
        if ($urandom % 8 != 0) host_wdata[2] = m_srst;
      end else idle();
      tick();
    end
    idle();
    tick();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule